// File: doc/BRIEF.md
# PS/2 Keyboard Hexadecimal Digit Display

This block listens to a PS/2 keyboard and shows the last hexadecimal key pressed on one digit of a four-digit, multiplexed 7-segment display. It runs entirely on the system clock. The keyboard clock and data lines are inputs only. Both lines pass through a synchronizer, and the block finds falling edges of the keyboard clock by comparing consecutive synchronized samples. The keyboard clock never reaches a flip-flop clock pin.

Each received frame is checked for its framing bits and its parity. A good frame yields one scan-code byte. Make codes for the keys 0–9 and a–f select a segment pattern. Any other key blanks the digit. Key releases are ignored, and an asynchronous reset blanks the display. The block sits between the board's keyboard pins and the display pins, with no software interface.

Top module: `kbd_hex_display`

## Requirements
- R1: While `rst_i` is high, `seg_n_o` is 8'hFF (all segments and the point dark), without waiting for a clock edge. After reset the display stays blank until a recognized key arrives.
- R2: `digit_sel_n_o` is active low. Only bit `DIGIT_SEL` is 0 and every other bit is 1, at all times, including during reset.
- R3: A frame has 11 bits, sampled from the data line on each falling edge of the synchronized keyboard clock, in this order: start bit (0), eight data bits least significant first, odd parity bit, stop bit (1).
- R4: Segment outputs are active low, with bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f, 6 = g and bit 7 = decimal point. The point is always off (1). An accepted make code lights exactly these segments:
  - 0x45 → 0: abcdef
  - 0x16 → 1: bc
  - 0x1E → 2: abdeg
  - 0x26 → 3: abcdg
  - 0x25 → 4: bcfg
  - 0x2E → 5: acdfg
  - 0x36 → 6: acdefg
  - 0x3D → 7: abc
  - 0x3E → 8: abcdefg
  - 0x46 → 9: abcdfg
  - 0x1C → A: abcefg
  - 0x32 → b: cdefg
  - 0x21 → C: adef
  - 0x23 → d: bcdeg
  - 0x24 → E: adefg
  - 0x2B → F: aefg
- R5: Any other accepted byte that is not 0xF0 blanks the digit (`seg_n_o` = 8'hFF). This includes the extended prefix 0xE0.
- R6: An accepted 0xF0 leaves the display unchanged. The next accepted byte after it is ignored and does not change the display; the byte after that is decoded normally.
- R7: A frame with start bit 1, stop bit 0, or even parity over the data and parity bits is discarded. The display keeps its previous content.
- R8: If the keyboard clock stays high for `TIMEOUT_CYCLES` system cycles while a frame is partly received, the partial frame is dropped. The next falling edge is taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| kb_clk_i | input | 1 | Keyboard clock line, sampled as data |
| kb_data_i | input | 1 | Keyboard data line |
| digit_sel_n_o | output | NUM_DIGITS | Active-low digit enables |
| seg_n_o | output | 8 | Active-low segments a–g and decimal point |

## Verification
The bench builds the block with `DIGIT_SEL` = 2 and `TIMEOUT_CYCLES` = 200, and drives a keyboard bit period of 16 system cycles. With a bit period that short, every one of the 256 byte values except 0xF0 can be sent as a key after a known preset. The bench checks each result against segment sets it derives from letter lists, which covers the whole make-code table and the blanking rule. The short timeout also puts a stalled half-frame within reach, followed by recovery on the next frame. Separate sequences cover the release prefix, each kind of framing fault, and a reset applied between clock edges.

// File: rtl/kbd_hex_pkg.sv
package kbd_hex_pkg;

  localparam logic [7:0] RELEASE_CODE = 8'hF0;
  localparam logic [7:0] EXTEND_CODE  = 8'hE0;

  typedef struct packed {
    logic       hit;
    logic [3:0] value;
  } key_hit_t;

  // active-high segment set, bit0 = a ... bit6 = g
  function automatic logic [6:0] glyph_of(input logic [3:0] v);
    case (v)
      4'h0: glyph_of = 7'h3F;
      4'h1: glyph_of = 7'h06;
      4'h2: glyph_of = 7'h5B;
      4'h3: glyph_of = 7'h4F;
      4'h4: glyph_of = 7'h66;
      4'h5: glyph_of = 7'h6D;
      4'h6: glyph_of = 7'h7D;
      4'h7: glyph_of = 7'h07;
      4'h8: glyph_of = 7'h7F;
      4'h9: glyph_of = 7'h6F;
      4'hA: glyph_of = 7'h77;
      4'hB: glyph_of = 7'h7C;
      4'hC: glyph_of = 7'h39;
      4'hD: glyph_of = 7'h5E;
      4'hE: glyph_of = 7'h79;
      default: glyph_of = 7'h71;
    endcase
  endfunction

  function automatic key_hit_t lookup_key(input logic [7:0] code);
    key_hit_t r;
    r.hit = 1'b1;
    case (code)
      8'h45: r.value = 4'h0;
      8'h16: r.value = 4'h1;
      8'h1E: r.value = 4'h2;
      8'h26: r.value = 4'h3;
      8'h25: r.value = 4'h4;
      8'h2E: r.value = 4'h5;
      8'h36: r.value = 4'h6;
      8'h3D: r.value = 4'h7;
      8'h3E: r.value = 4'h8;
      8'h46: r.value = 4'h9;
      8'h1C: r.value = 4'hA;
      8'h32: r.value = 4'hB;
      8'h21: r.value = 4'hC;
      8'h23: r.value = 4'hD;
      8'h24: r.value = 4'hE;
      8'h2B: r.value = 4'hF;
      default: begin
        r.hit   = 1'b0;
        r.value = 4'h0;
      end
    endcase
    return r;
  endfunction

  // frame[0]=start, [8:1]=data, [9]=parity, [10]=stop
  function automatic logic frame_is_good(input logic [10:0] f);
    return (f[0] == 1'b0) && (f[10] == 1'b1) && (^f[9:1] == 1'b1);
  endfunction

endpackage

// File: rtl/kb_line_sync.sv
module kb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic din_i,
  output logic dout_o
);
  logic [STAGES-1:0] q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) q[0] <= 1'b1;
        else       q[0] <= din_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) q[g] <= 1'b1;
        else       q[g] <= q[g-1];
      end
    end
  end

  assign dout_o = q[STAGES-1];
endmodule

// File: rtl/kb_frame_rx.sv
module kb_frame_rx
  import kbd_hex_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       kb_clk_i,
  input  logic       kb_data_i,
  output logic [7:0] byte_o,
  output logic       byte_ok_o,
  output logic       byte_bad_o,
  output logic       timeout_o
);
  localparam int FRAME_BITS = 11;
  localparam int CW = $clog2(FRAME_BITS);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);
  localparam logic [TW-1:0] IDLE_LAST = TW'(TIMEOUT_CYCLES - 1);

  logic kclk_s, kdat_s, kclk_q;
  logic fall;
  logic [CW-1:0] bit_cnt;
  logic [FRAME_BITS-2:0] shreg;
  logic [TW-1:0] idle_cnt;
  logic frame_done;
  logic [FRAME_BITS-1:0] frame;

  kb_line_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk_i(clk_i), .rst_i(rst_i), .din_i(kb_clk_i), .dout_o(kclk_s));
  kb_line_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk_i(clk_i), .rst_i(rst_i), .din_i(kb_data_i), .dout_o(kdat_s));

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) kclk_q <= 1'b1;
    else       kclk_q <= kclk_s;
  end

  assign fall       = kclk_q & ~kclk_s;
  assign frame_done = fall && (bit_cnt == LAST_BIT);
  assign frame      = {kdat_s, shreg};
  assign timeout_o  = kclk_s && (bit_cnt != '0) && (idle_cnt == IDLE_LAST);

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      idle_cnt <= '0;
    end else if (!kclk_s || bit_cnt == '0 || timeout_o) begin
      idle_cnt <= '0;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_o     <= '0;
      byte_ok_o  <= 1'b0;
      byte_bad_o <= 1'b0;
    end else begin
      byte_ok_o  <= 1'b0;
      byte_bad_o <= 1'b0;
      if (timeout_o) begin
        bit_cnt <= '0;
      end else if (frame_done) begin
        bit_cnt    <= '0;
        byte_o     <= frame[8:1];
        byte_ok_o  <= frame_is_good(frame);
        byte_bad_o <= !frame_is_good(frame);
      end else if (fall) begin
        shreg   <= {kdat_s, shreg[FRAME_BITS-2:1]};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R3
  bit_cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    bit_cnt <= LAST_BIT);
  // R7
  one_verdict_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({byte_ok_o, byte_bad_o}));
  // R8
  timeout_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    timeout_o |=> (bit_cnt == '0) && !byte_ok_o && !byte_bad_o);
  // R3
  verdict_needs_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (byte_ok_o || byte_bad_o) |-> $past(fall));
endmodule

// File: rtl/hex_key_decode.sv
module hex_key_decode
  import kbd_hex_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [7:0] byte_i,
  input  logic       byte_ok_i,
  input  logic       byte_bad_i,
  output logic       show_o,
  output logic [3:0] nibble_o
);
  logic release_pend;
  key_hit_t hit;

  assign hit = lookup_key(byte_i);

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      release_pend <= 1'b0;
      show_o       <= 1'b0;
      nibble_o     <= '0;
    end else if (byte_ok_i) begin
      if (byte_i == RELEASE_CODE) begin
        release_pend <= 1'b1;
      end else if (release_pend) begin
        release_pend <= 1'b0;
      end else begin
        show_o   <= hit.hit;
        nibble_o <= hit.value;
      end
    end
  end

  // R6
  release_skip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (byte_ok_i && release_pend && byte_i != RELEASE_CODE)
      |=> $stable(show_o) && $stable(nibble_o) && !release_pend);
  // R6
  release_arms_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (byte_ok_i && byte_i == RELEASE_CODE) |=> release_pend && $stable(show_o));
  // R7
  bad_frame_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    byte_bad_i |=> $stable(show_o) && $stable(nibble_o));
  // R5
  extend_blanks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (byte_ok_i && !release_pend && byte_i == EXTEND_CODE) |=> !show_o);
endmodule

// File: rtl/seg_digit_drive.sv
module seg_digit_drive
  import kbd_hex_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int DIGIT_SEL  = 0
) (
  input  logic                  show_i,
  input  logic [3:0]            nibble_i,
  output logic [NUM_DIGITS-1:0] digit_sel_n_o,
  output logic [7:0]            seg_n_o
);
  localparam logic [NUM_DIGITS-1:0] SEL_MASK = NUM_DIGITS'(1) << DIGIT_SEL;

  assign digit_sel_n_o = ~SEL_MASK;

  always_comb begin
    if (show_i) seg_n_o = {1'b1, ~glyph_of(nibble_i)};
    else        seg_n_o = 8'hFF;
  end

  // R4
  always_comb begin
    point_dark_chk: assert (seg_n_o[7] == 1'b1 || $isunknown(seg_n_o));
  end
endmodule

// File: rtl/kbd_hex_display.sv
module kbd_hex_display #(
  parameter int NUM_DIGITS     = 4,
  parameter int DIGIT_SEL      = 0,
  parameter int SYNC_STAGES    = 2,
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  kb_clk_i,
  input  logic                  kb_data_i,
  output logic [NUM_DIGITS-1:0] digit_sel_n_o,
  output logic [7:0]            seg_n_o
);
  logic [7:0] rx_byte;
  logic       rx_ok, rx_bad, rx_timeout;
  logic       show;
  logic [3:0] nibble;

  kb_frame_rx #(.SYNC_STAGES(SYNC_STAGES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_rx (
    .clk_i(clk_i), .rst_i(rst_i), .kb_clk_i(kb_clk_i), .kb_data_i(kb_data_i),
    .byte_o(rx_byte), .byte_ok_o(rx_ok), .byte_bad_o(rx_bad), .timeout_o(rx_timeout));

  hex_key_decode u_dec (
    .clk_i(clk_i), .rst_i(rst_i), .byte_i(rx_byte), .byte_ok_i(rx_ok),
    .byte_bad_i(rx_bad), .show_o(show), .nibble_o(nibble));

  seg_digit_drive #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_SEL(DIGIT_SEL)) u_drv (
    .show_i(show), .nibble_i(nibble), .digit_sel_n_o(digit_sel_n_o), .seg_n_o(seg_n_o));

  // R2
  one_digit_chk: assert property (@(posedge clk_i)
    $countones(~digit_sel_n_o) == 1 && digit_sel_n_o[DIGIT_SEL] == 1'b0);
  // R8
  timeout_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rx_timeout |=> $stable(seg_n_o));
endmodule

// File: tb/kbd_hex_display_tb.sv
module kbd_hex_display_tb;
  localparam int SEL   = 2;
  localparam int TOUT  = 200;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic kclk = 1'b1;
  logic kdat = 1'b1;
  logic [3:0] an;
  logic [7:0] seg;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  kbd_hex_display #(.NUM_DIGITS(4), .DIGIT_SEL(SEL), .SYNC_STAGES(2),
                    .TIMEOUT_CYCLES(TOUT)) u_dut (
    .clk_i(clk), .rst_i(rst), .kb_clk_i(kclk), .kb_data_i(kdat),
    .digit_sel_n_o(an), .seg_n_o(seg));

  function automatic logic [7:0] code_of(input int v);
    case (v)
      0: return 8'h45;  1: return 8'h16;  2: return 8'h1E;  3: return 8'h26;
      4: return 8'h25;  5: return 8'h2E;  6: return 8'h36;  7: return 8'h3D;
      8: return 8'h3E;  9: return 8'h46;  10: return 8'h1C; 11: return 8'h32;
      12: return 8'h21; 13: return 8'h23; 14: return 8'h24; default: return 8'h2B;
    endcase
  endfunction

  function automatic string lit_of(input int v);
    case (v)
      0: return "abcdef";  1: return "bc";     2: return "abdeg";  3: return "abcdg";
      4: return "bcfg";    5: return "acdfg";  6: return "acdefg"; 7: return "abc";
      8: return "abcdefg"; 9: return "abcdfg"; 10: return "abcefg"; 11: return "cdefg";
      12: return "adef";   13: return "bcdeg"; 14: return "adefg"; default: return "aefg";
    endcase
  endfunction

  function automatic logic [7:0] expect_for(input logic [7:0] code);
    logic [7:0] r;
    r = 8'hFF;
    for (int v = 0; v < 16; v++) begin
      if (code_of(v) == code) begin
        string s;
        s = lit_of(v);
        for (int k = 0; k < s.len(); k++) r[s[k] - "a"] = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    kdat = b;
    wait_clk(HALF);
    kclk = 1'b0;
    wait_clk(HALF);
    kclk = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_start,
                            input bit bad_par, input bit bad_stop);
    send_bit(bad_start);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(~^d ^ bad_par);
    send_bit(~bad_stop);
    kdat = 1'b1;
    wait_clk(20);
  endtask

  task automatic key(input logic [7:0] d);
    send_frame(d, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    // R1 R2 reset state
    check("R1", seg, 8'hFF);
    check("R2", {4'h0, an}, {4'h0, 4'b1011});
    rst = 1'b0;
    wait_clk(5);
    check("R1", seg, 8'hFF);

    // R3 R4 R5 sweep of all byte values
    for (int c = 0; c < 256; c++) begin
      if (c != 8'hF0) begin
        key(8'h16);
        key(8'(c));
        check(expect_for(8'(c)) == 8'hFF ? "R5" : "R4", seg, expect_for(8'(c)));
      end
    end
    check("R2", {4'h0, an}, {4'h0, 4'b1011});

    // R6 release prefix
    key(8'h1E);
    key(8'hF0);
    check("R6", seg, expect_for(8'h1E));
    key(8'h16);
    check("R6", seg, expect_for(8'h1E));
    key(8'h16);
    check("R6", seg, expect_for(8'h16));
    key(8'hF0);
    key(8'h55);
    check("R6", seg, expect_for(8'h16));

    // R5 extended prefix blanks
    key(8'h24);
    key(8'hE0);
    check("R5", seg, 8'hFF);

    // R7 framing faults
    key(8'h2E);
    send_frame(8'h45, 1'b0, 1'b1, 1'b0);
    check("R7", seg, expect_for(8'h2E));
    send_frame(8'h45, 1'b1, 1'b0, 1'b0);
    check("R7", seg, expect_for(8'h2E));
    send_frame(8'h45, 1'b0, 1'b0, 1'b1);
    check("R7", seg, expect_for(8'h2E));
    key(8'h45);
    check("R7", seg, expect_for(8'h45));

    // R8 stalled half frame then recovery
    send_bit(1'b0);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    wait_clk(TOUT + 50);
    check("R8", seg, expect_for(8'h45));
    key(8'h25);
    check("R8", seg, expect_for(8'h25));

    // R1 asynchronous reset between edges
    key(8'h3D);
    check("R4", seg, expect_for(8'h3D));
    @(negedge clk);
    #1 rst = 1'b1;
    #0.5;
    check("R1", seg, 8'hFF);
    check("R2", {4'h0, an}, {4'h0, 4'b1011});
    wait_clk(3);
    rst = 1'b0;
    wait_clk(10);
    check("R1", seg, 8'hFF);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule